// File: doc/BRIEF.md
# Pseudo-SRAM power-up and deep power-down sequencer

This block owns the power-control side of an asynchronous-interface pseudo-SRAM. It drives the active-high chip enable that puts the memory into deep power-down. It can also force the active-low chip enable high, whatever the access controller asks for. All waits come from cycle-count parameters, so one block covers any clock rate. The waits are:

- the low hold after the supply becomes good;
- the setup before and after each edge of the power-control enable;
- the long recovery interval after the power-control enable rises.

Normal accesses are allowed only while the ready flag is high. A sleep request is honoured only from the ready (standby) state. If the sleep request arrives while an access is in flight, the block holds it until the access finishes. Any request that arrives while a sequence is running is dropped. The memory does not keep its contents through deep power-down. For that reason the block sets a contents-lost flag when it wakes the memory, and the first write after wake-up clears that flag.

Top module: `psram_pwr_seq`

## Requirements
- R1: Asynchronous reset gives power enable low, force-high asserted, ready low and contents-lost low.
- R2: When the supply-good input goes high, the power enable stays low for one idle cycle plus PUP_CYC more cycles, then rises.
- R3: The force-high output is asserted in every cycle where the power enable is low. It stays asserted through the cycle in which the power enable rises and for REC_CYC cycles in total after that rise. Only after those REC_CYC cycles does ready go high.
- R4: Ready is high only after a completed recovery interval, and only until a sleep sequence or a supply loss begins. While ready is high, the gated enable `ce1_n_o` follows `ce1_n_i`. In all other cycles `ce1_n_o` is 1.
- R5: A sleep request in the ready state with no access busy forces the active-low enable high for SET_CYC cycles while the power enable is still high. The power enable then goes low and stays low for at least PDH_CYC cycles before a wake request is accepted.
- R6: A sleep request that arrives while the busy input is high is held. Ready stays high until busy drops. The sleep sequence starts in the first cycle with busy low, even if the request has been removed by then.
- R7: A wake request in power-down holds the power enable low, with force-high asserted, for SET_CYC cycles. The power enable then rises and the full REC_CYC recovery runs before ready goes high.
- R8: The block ignores a wake request outside the power-down state and a sleep request outside the ready state. Neither kind is remembered for later.
- R9: The contents-lost flag goes high in the cycle the power enable rises at the end of a wake. It clears on the clock after a write strobe seen while ready is high. A write strobe while ready is low has no effect on the flag.
- R10: If the supply-good input is low at a clock edge, the next cycle has the power enable low, ready low and force-high asserted. The power-up wait of R2 then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Memory supply is within range |
| sleep_req_i | input | 1 | Request to enter deep power-down |
| wake_req_i | input | 1 | Request to leave deep power-down |
| busy_i | input | 1 | An access to the memory is in progress |
| wr_i | input | 1 | Write strobe from the access controller |
| ce1_n_i | input | 1 | Active-low enable requested by the access controller |
| ce2_o | output | 1 | Memory power-control enable, active high |
| ce1_force_o | output | 1 | Override holding the active-low enable high |
| ce1_n_o | output | 1 | Gated active-low enable to the memory |
| ready_o | output | 1 | Normal accesses permitted |
| lost_o | output | 1 | Memory contents invalid since the last wake |

## Verification
The sequencer is tried with several input patterns:

- A cold power-up with supply-good held off for a while. This separates the initial low hold from the recovery interval.
- A clean sleep, and a sleep raised during a busy access. These show whether a sleep request is acted on at once or held until the access completes.
- Wake and sleep requests placed inside the setup, hold and recovery windows. These must be dropped, which shows the difference between accepted requests and refused ones.
- Write strobes before and after ready returns. These show whether the contents-lost flag clears only on a genuine write.
- Supply drops from the ready state and from the middle of recovery. These confirm that the sequence restarts from the beginning.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,  // supply not good
    ST_PUP  = 3'd1,  // initial power enable low hold
    ST_REC  = 3'd2,  // power enable high, recovery wait
    ST_RDY  = 3'd3,  // standby / active
    ST_QUI  = 3'd4,  // enable forced high before power-down
    ST_PDH  = 3'd5,  // minimum power-down hold
    ST_PD   = 3'd6,  // deep power-down
    ST_WSET = 3'd7   // setup before power enable rises on wake
  } pwr_st_e;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_lost_flag.sv
module pwr_seq_lost_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic lost_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lost_o <= 1'b0;
    else if (set_i)  lost_o <= 1'b1;
    else if (clr_i)  lost_o <= 1'b0;
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int PUP_CYC = 5000,
  parameter int REC_CYC = 35000,
  parameter int SET_CYC = 2,
  parameter int PDH_CYC = 10,
  parameter int CW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          supply_ok_i,
  input  logic          sleep_req_i,
  input  logic          wake_req_i,
  input  logic          busy_i,
  input  logic          tmr_done_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          wake_done_o,
  output pwr_st_e       st_o
);
  localparam logic [CW-1:0] PUP_LD = CW'(PUP_CYC - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] SET_LD = CW'(SET_CYC - 1);
  localparam logic [CW-1:0] PDH_LD = CW'(PDH_CYC - 1);

  pwr_st_e st_q, st_d;
  logic    pend_q;
  logic    go_sleep;

  assign go_sleep = (sleep_req_i || pend_q) && !busy_i;

  always_comb begin
    st_d        = st_q;
    tmr_load_o  = 1'b0;
    tmr_val_o   = '0;
    wake_done_o = 1'b0;
    if (!supply_ok_i) begin
      st_d = ST_OFF;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_d = ST_PUP; tmr_load_o = 1'b1; tmr_val_o = PUP_LD;
        end
        ST_PUP: if (tmr_done_i) begin
          st_d = ST_REC; tmr_load_o = 1'b1; tmr_val_o = REC_LD;
        end
        ST_REC: if (tmr_done_i) st_d = ST_RDY;
        ST_RDY: if (go_sleep) begin
          st_d = ST_QUI; tmr_load_o = 1'b1; tmr_val_o = SET_LD;
        end
        ST_QUI: if (tmr_done_i) begin
          st_d = ST_PDH; tmr_load_o = 1'b1; tmr_val_o = PDH_LD;
        end
        ST_PDH: if (tmr_done_i) st_d = ST_PD;
        ST_PD: if (wake_req_i) begin
          st_d = ST_WSET; tmr_load_o = 1'b1; tmr_val_o = SET_LD;
        end
        ST_WSET: if (tmr_done_i) begin
          st_d = ST_REC; tmr_load_o = 1'b1; tmr_val_o = REC_LD;
          wake_done_o = 1'b1;
        end
        default: st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      // sleep seen during a busy access is kept while ready
      pend_q <= supply_ok_i && (st_q == ST_RDY) && busy_i && (pend_q || sleep_req_i);
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int PUP_CYC = 5000,
  parameter int REC_CYC = 35000,
  parameter int SET_CYC = 2,
  parameter int PDH_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic busy_i,
  input  logic wr_i,
  input  logic ce1_n_i,
  output logic ce2_o,
  output logic ce1_force_o,
  output logic ce1_n_o,
  output logic ready_o,
  output logic lost_o
);
  localparam int MAX_AB = (PUP_CYC > REC_CYC) ? PUP_CYC : REC_CYC;
  localparam int MAX_CD = (SET_CYC > PDH_CYC) ? SET_CYC : PDH_CYC;
  localparam int MAX_C  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CW     = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  pwr_st_e       st;
  logic          tmr_load, tmr_done, wake_done;
  logic [CW-1:0] tmr_val;

  pwr_seq_fsm #(
    .PUP_CYC(PUP_CYC), .REC_CYC(REC_CYC), .SET_CYC(SET_CYC),
    .PDH_CYC(PDH_CYC), .CW(CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .supply_ok_i(supply_ok_i),
    .sleep_req_i(sleep_req_i),
    .wake_req_i (wake_req_i),
    .busy_i     (busy_i),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .wake_done_o(wake_done),
    .st_o       (st)
  );

  pwr_seq_timer #(.CW(CW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .done_o(tmr_done)
  );

  pwr_seq_lost_flag u_lost (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (wake_done),
    .clr_i (ready_o && wr_i),
    .lost_o(lost_o)
  );

  assign ce2_o       = (st == ST_REC) || (st == ST_RDY) || (st == ST_QUI);
  assign ready_o     = (st == ST_RDY);
  assign ce1_force_o = !ready_o;
  assign ce1_n_o     = ce1_force_o ? 1'b1 : ce1_n_i;
endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int PUP_CYC = 5000,
  parameter int SET_CYC = 2,
  parameter int PDH_CYC = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic wr_i,
  input logic ce2_o,
  input logic ce1_force_o,
  input logic ce1_n_o,
  input logic ready_o,
  input logic lost_o
);
  localparam int LOW_A   = PUP_CYC + 1;
  localparam int LOW_B   = PDH_CYC + 1 + SET_CYC;
  localparam int MIN_LOW = (LOW_A < LOW_B) ? LOW_A : LOW_B;

  int unsigned low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            low_run <= 0;
    else if (ce2_o)         low_run <= 0;
    else if (low_run < 32'hFFFF_FFF0) low_run <= low_run + 1;
  end

  AST_FORCE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce2_o) |-> ce1_force_o); // R3
  AST_READY_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ce2_o && !ce1_force_o)); // R4
  AST_GATE_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> ce1_n_o); // R4
  AST_FORCED_BEFORE_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ce2_o) && $past(supply_ok_i)) |-> $past(ce1_force_o)); // R5
  AST_MIN_LOW_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce2_o) |-> (low_run >= MIN_LOW)); // R5
  AST_SUPPLY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (!ce2_o && !ready_o && ce1_force_o)); // R10
  AST_LOST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && wr_i) |=> !lost_o); // R9
  AST_LOST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> $rose(ce2_o)); // R9
endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .PUP_CYC(PUP_CYC), .SET_CYC(SET_CYC), .PDH_CYC(PDH_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .wr_i       (wr_i),
  .ce2_o      (ce2_o),
  .ce1_force_o(ce1_force_o),
  .ce1_n_o    (ce1_n_o),
  .ready_o    (ready_o),
  .lost_o     (lost_o)
);

// File: tb/psram_pwr_seq_bench.sv
module psram_pwr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PUP = 5;
  localparam int REC = 8;
  localparam int SET = 2;
  localparam int PDH = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply = 1'b0, sleep = 1'b0, wake = 1'b0, busy = 1'b0, wr = 1'b0, ce1_in = 1'b1;
  logic ce2, force_hi, ce1_out, ready, lost;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  psram_pwr_seq #(.PUP_CYC(PUP), .REC_CYC(REC), .SET_CYC(SET), .PDH_CYC(PDH)) u_psram_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply), .sleep_req_i(sleep),
    .wake_req_i(wake), .busy_i(busy), .wr_i(wr), .ce1_n_i(ce1_in),
    .ce2_o(ce2), .ce1_force_o(force_hi), .ce1_n_o(ce1_out), .ready_o(ready), .lost_o(lost)
  );

  // behavioural reference: phase name plus cycles remaining in the phase
  string m_ph = "off";
  int    m_left = 0;
  bit    m_pend = 0;
  bit    m_lost = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = "off"; m_left = 0; m_pend = 0; m_lost = 0;
    end else begin
      if (m_ph == "ready" && wr) m_lost = 0;
      if (!supply) begin
        m_ph = "off"; m_pend = 0;
      end else if (m_ph == "off") begin
        m_ph = "hold"; m_left = PUP;
      end else if (m_ph == "ready") begin
        if ((sleep || m_pend) && !busy) begin
          m_ph = "quiesce"; m_left = SET; m_pend = 0;
        end else m_pend = busy && (m_pend || sleep);
      end else if (m_ph == "down") begin
        if (wake) begin m_ph = "wakeset"; m_left = SET; end
      end else if (m_left > 1) begin
        m_left--;
      end else begin
        case (m_ph)
          "hold":    begin m_ph = "recover"; m_left = REC; end
          "recover": m_ph = "ready";
          "quiesce": begin m_ph = "pdhold"; m_left = PDH; end
          "pdhold":  m_ph = "down";
          "wakeset": begin m_ph = "recover"; m_left = REC; m_lost = 1; end
          default:   m_ph = "off";
        endcase
      end
    end
  end

  task automatic cmp(input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b phase=%s t=%0t", cur_tag, what, act, exp, m_ph, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      begin
        logic e_ce2, e_rdy;
        e_ce2 = (m_ph == "recover") || (m_ph == "ready") || (m_ph == "quiesce");
        e_rdy = (m_ph == "ready");
        cmp("power_enable", ce2, e_ce2);
        cmp("force_high", force_hi, !e_rdy);
        cmp("ready", ready, e_rdy);
        cmp("gated_enable", ce1_out, e_rdy ? ce1_in : 1'b1);
        cmp("contents_lost", lost, m_lost);
      end
    end
  endtask

  initial begin
    cur_tag = "R1";
    step(3);
    rst_n = 1'b1;
    step(4);                       // supply still bad: stays off
    cur_tag = "R2";
    supply = 1'b1;
    step(7);
    cur_tag = "R3";
    sleep = 1'b1; wake = 1'b1;     // R8 sleep/wake during power-up ignored
    step(3);
    sleep = 1'b0; wake = 1'b0;
    step(8);
    cur_tag = "R4";
    for (int k = 0; k < 6; k++) begin
      ce1_in = k[0];
      wake = (k == 2);             // wake while ready ignored
      step(1);
    end
    wake = 1'b0; ce1_in = 1'b1;
    cur_tag = "R6";
    busy = 1'b1; sleep = 1'b1;
    step(1);
    sleep = 1'b0;
    step(4);                       // still ready, request held
    busy = 1'b0;
    step(2);
    cur_tag = "R8";
    wake = 1'b1;                   // wake during setup/hold ignored
    step(4);
    wake = 1'b0;
    step(4);                       // parked in power-down
    cur_tag = "R7";
    wake = 1'b1;
    step(1);
    wake = 1'b0;
    cur_tag = "R9";
    step(4);
    wr = 1'b1;                     // not ready: no effect on flag
    step(3);
    wr = 1'b0;
    step(6);
    wr = 1'b1;
    step(1);
    wr = 1'b0;
    step(2);
    cur_tag = "R5";
    sleep = 1'b1;
    step(1);
    sleep = 1'b0;
    step(SET + PDH + 3);
    wake = 1'b1;
    step(1);
    wake = 1'b0;
    step(SET + 4);
    cur_tag = "R10";
    supply = 1'b0;                 // drop mid-recovery
    step(2);
    supply = 1'b1;
    step(PUP + REC + 4);
    supply = 1'b0;                 // drop from ready
    step(2);
    supply = 1'b1;
    step(PUP + REC + 3);
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_tag);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule